// File: doc/BRIEF.md
# Vector Halfword Shift-Left Execution Unit

This block executes a single vector instruction. It accepts a 32-bit VX-form instruction word, checks the word's primary and extended opcodes, and reads two 128-bit source vectors from its own 32-entry register file. Each source is split into eight 16-bit lanes. Every lane of the first source is shifted left by a count taken from the same lane of the second source, and the resulting vector is written back to the destination register.

The instruction is accepted on a rising clock edge while the valid strobe is high, and the destination is written on that same edge. A completion pulse follows one cycle later. A word with any other opcode produces a one-cycle illegal-instruction pulse and leaves the register file untouched. A debug write port preloads registers, and a debug read port with a registered output exposes their contents.

Top module: `vshl_unit`

## Requirements
- R1: A word presented with `instr_valid` high is executed when bits [31:26] (primary opcode, the most significant bits) equal 4 and bits [10:0] (extended opcode) equal 324. An example is 0x10000144 with all register fields zero. `done` is high for exactly the one cycle after the accepting edge.
- R2: Bits [25:21] of the word select the destination register, bits [20:16] select source A and bits [15:11] select source B.
- R3: Lane k of the result is lane k of A shifted left by the count in lane k of B, for k = 0..7.
- R4: Only the low 4 bits of each B lane form the count (0..15). The upper 12 bits of each B lane have no effect.
- R5: The shift is logical. Zeros enter at the low end, bits pushed beyond bit 15 of a lane are lost, and no bit moves into a neighbouring lane.
- R6: Lanes are numbered big-endian: lane 0 occupies bits [127:112] and lane 7 occupies bits [15:0].
- R7: When the destination equals a source register, the source value used is the one held before the write.
- R8: A valid word whose primary or extended opcode differs raises `illegal` for exactly one cycle, does not raise `done`, and writes no register.
- R9: A synchronous active-high reset clears all 32 registers, `done` and `illegal`.
- R10: `dbg_we` writes `dbg_wdata` into register `dbg_waddr` on the clock edge. `dbg_rdata` shows register `dbg_raddr` one cycle after the address is applied.
- R11: When an executed instruction and a debug write target the same register on the same edge, the instruction result is stored.
- R12: While `instr_valid` is low the instruction word has no effect: no register changes and neither `done` nor `illegal` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 32 | VX-form instruction word |
| done | output | 1 | Completion pulse, one cycle after acceptance |
| illegal | output | 1 | Unrecognised-opcode pulse |
| dbg_we | input | 1 | Debug register write enable |
| dbg_waddr | input | 5 | Debug write register index |
| dbg_wdata | input | 128 | Debug write data |
| dbg_raddr | input | 5 | Debug read register index |
| dbg_rdata | output | 128 | Registered debug read data |

## Verification
A stale or mis-steered write-enable in the register file is only visible through the debug read port. It appears one cycle after the affected register's index is applied to `dbg_raddr`, so every stimulus is followed by a read-back of the destination register and of the registers around it. A wrong lane slice, a count mask that is too wide, or a carry between lanes corrupts the destination value that is read back right after the instruction. A decode fault shows on the very next cycle as a wrong `done` or `illegal` pulse.

// File: rtl/vshl_pkg.sv
package vshl_pkg;
  localparam int unsigned RF_AW   = 5;
  localparam int unsigned NREG    = 1 << RF_AW;
  localparam logic [5:0]  OP_PRI  = 6'd4;
  localparam logic [10:0] OP_EXT  = 11'd324;

  // Field layout of a VX word; the most significant field comes first.
  typedef struct packed {
    logic [5:0]       pri;
    logic [RF_AW-1:0] dst;
    logic [RF_AW-1:0] srca;
    logic [RF_AW-1:0] srcb;
    logic [10:0]      ext;
  } vx_word_t;
endpackage

// File: rtl/vshl_decode.sv
module vshl_decode
  import vshl_pkg::*;
(
  input  logic [31:0]      word,
  output logic             match,
  output logic [RF_AW-1:0] dst,
  output logic [RF_AW-1:0] srca,
  output logic [RF_AW-1:0] srcb
);
  vx_word_t f;
  always_comb begin
    f     = vx_word_t'(word);
    match = (f.pri == OP_PRI) && (f.ext == OP_EXT);
    dst   = f.dst;
    srca  = f.srca;
    srcb  = f.srcb;
  end
endmodule

// File: rtl/vshl_lanes.sv
module vshl_lanes #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned LANE_W = 16
) (
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic [VEC_W-1:0] result
);
  localparam int unsigned LANES = VEC_W / LANE_W;
  localparam int unsigned CNT_W = $clog2(LANE_W);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // lane 0 is the most significant slice
    localparam int unsigned HI = VEC_W - 1 - k * LANE_W;
    logic [LANE_W-1:0] a_l;
    logic [LANE_W-1:0] b_l;
    logic [CNT_W-1:0]  cnt;
    assign a_l = src_a[HI -: LANE_W];
    assign b_l = src_b[HI -: LANE_W];
    assign cnt = b_l[CNT_W-1:0];
    assign result[HI -: LANE_W] = a_l << cnt;
  end
endmodule

// File: rtl/vshl_regfile.sv
module vshl_regfile #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned AW     = 5,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);
  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_data <= '0;
    else     dbg_data <= regs[dbg_addr];
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
endmodule

// File: rtl/vshl_unit.sv
module vshl_unit
  import vshl_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  output logic              done,
  output logic              illegal,
  input  logic              dbg_we,
  input  logic [RF_AW-1:0]  dbg_waddr,
  input  logic [VEC_W-1:0]  dbg_wdata,
  input  logic [RF_AW-1:0]  dbg_raddr,
  output logic [VEC_W-1:0]  dbg_rdata
);
  logic             match;
  logic [RF_AW-1:0] dst, srca, srcb;
  logic [VEC_W-1:0] va, vb, vres;
  logic             exec;
  logic             wr_en;
  logic [RF_AW-1:0] wr_addr;
  logic [VEC_W-1:0] wr_data;

  vshl_decode u_dec (
    .word (instr_word), .match (match),
    .dst (dst), .srca (srca), .srcb (srcb)
  );

  vshl_lanes #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_lanes (
    .src_a (va), .src_b (vb), .result (vres)
  );

  assign exec = instr_valid && match;

  // one shared write port; an executing instruction wins over debug
  always_comb begin
    wr_en   = exec || dbg_we;
    wr_addr = exec ? dst  : dbg_waddr;
    wr_data = exec ? vres : dbg_wdata;
  end

  vshl_regfile #(.DATA_W(VEC_W), .AW(RF_AW)) u_rf (
    .clk (clk), .rst (rst),
    .ra_addr (srca), .ra_data (va),
    .rb_addr (srcb), .rb_data (vb),
    .we (wr_en), .waddr (wr_addr), .wdata (wr_data),
    .dbg_addr (dbg_raddr), .dbg_data (dbg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= exec;
      illegal <= instr_valid && !match;
    end
  end
endmodule

// File: rtl/vshl_checker.sv
module vshl_checker (
  input logic        clk,
  input logic        rst,
  input logic        instr_valid,
  input logic [31:0] instr_word,
  input logic        done,
  input logic        illegal
);
  logic hit;
  assign hit = (instr_word[31:26] == 6'd4) && (instr_word[10:0] == 11'd324);

  // R1: completion follows only an accepted matching word
  a_r1_done_after_match: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(instr_valid) && $past(hit)));

  // R1: every accepted matching word completes
  a_r1_match_gives_done: assert property (@(posedge clk) disable iff (rst)
    ($past(instr_valid) && $past(hit) && !$past(rst)) |-> done);

  // R8: illegal only after a valid mismatching word
  a_r8_illegal_cause: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($past(instr_valid) && !$past(hit)));

  // R8: the two outcomes are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && illegal));

  // R12: nothing happens without the strobe
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(instr_valid) |-> (!done && !illegal));
endmodule

bind vshl_unit vshl_checker u_chk (
  .clk (clk), .rst (rst), .instr_valid (instr_valid),
  .instr_word (instr_word), .done (done), .illegal (illegal)
);

// File: tb/sim_vshl_unit.sv
module sim_vshl_unit;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned VW = 128;
  localparam int unsigned NROWS = 6;

  // each row: {A, B}
  localparam logic [2*VW-1:0] VECS [NROWS] = '{
    {128'h0001_0001_0001_0001_0001_0001_0001_0001, 128'h0000_0001_0002_0003_0004_0005_0006_0007},
    {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'h000F_000F_000F_000F_000F_000F_000F_000F},
    {128'h8001_8001_8001_8001_8001_8001_8001_8001, 128'h0001_0001_0001_0001_0001_0001_0001_0001},
    {128'h1234_5678_9ABC_DEF0_0F0F_F0F0_AAAA_5555, 128'hFFF0_1230_0010_8000_FFF0_0020_0040_0F00},
    {128'h1234_5678_9ABC_DEF0_0F0F_F0F0_AAAA_5555, 128'h0013_FFF4_0008_800C_0002_0005_FFFE_0009},
    {128'hC3A5_0001_7FFF_8000_0100_00FF_F00F_1111, 128'h0007_000F_0001_0000_0008_0004_000C_0003}
  };

  logic           clk = 0;
  logic           rst;
  logic           instr_valid;
  logic [31:0]    instr_word;
  logic           done, illegal;
  logic           dbg_we;
  logic [4:0]     dbg_waddr, dbg_raddr;
  logic [VW-1:0]  dbg_wdata, dbg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  vshl_unit u0 (
    .clk, .rst, .instr_valid, .instr_word, .done, .illegal,
    .dbg_we, .dbg_waddr, .dbg_wdata, .dbg_raddr, .dbg_rdata
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] r;
    for (int k = 0; k < 8; k++) begin
      logic [15:0] al, bl;
      al = a[VW-1-16*k -: 16];
      bl = b[VW-1-16*k -: 16];
      r[VW-1-16*k -: 16] = 16'(al << bl[3:0]);
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] pri, input logic [4:0] d,
                                     input logic [4:0] a, input logic [4:0] b,
                                     input logic [10:0] x);
    return {pri, d, a, b, x};
  endfunction

  task automatic check(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [VW-1:0] d);
    @(negedge clk);
    dbg_we = 1; dbg_waddr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [VW-1:0] d);
    @(negedge clk);
    dbg_raddr = a;
    @(negedge clk);
    d = dbg_rdata;
  endtask

  // issue one word; returns done/illegal seen in the following cycle
  task automatic issue(input logic [31:0] w, input bit v, output logic dn, output logic il);
    @(negedge clk);
    instr_valid = v; instr_word = w;
    @(negedge clk);
    instr_valid = 0;
    dn = done; il = illegal;
    @(negedge clk);
    check("R1/R8 pulse width", {126'd0, done, illegal}, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] d;
    logic dn, il;
    rst = 1; instr_valid = 0; instr_word = '0;
    dbg_we = 0; dbg_waddr = '0; dbg_wdata = '0; dbg_raddr = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R9: reset state
    check("R9 done/illegal", {126'd0, done, illegal}, '0);
    rd(5'd0, d);  check("R9 reg0", d, '0);
    rd(5'd31, d); check("R9 reg31", d, '0);

    // table walk: R2, R3, R4, R5
    for (int i = 0; i < NROWS; i++) begin
      logic [4:0] ra, rb, rdst;
      ra = 5'(1 + 3*i); rb = 5'(2 + 3*i); rdst = 5'(31 - i);
      wr(ra, VECS[i][2*VW-1:VW]);
      wr(rb, VECS[i][VW-1:0]);
      issue(mk(6'd4, rdst, ra, rb, 11'd324), 1, dn, il);
      check("R1 done", {127'd0, dn}, 128'd1);
      check("R8 no illegal on match", {127'd0, il}, '0);
      rd(rdst, d);
      check("R3/R4/R5 lane shift", d, model(VECS[i][2*VW-1:VW], VECS[i][VW-1:0]));
      rd(ra, d);
      check("R2 source A kept", d, VECS[i][2*VW-1:VW]);
    end

    // R6: big-endian lanes, explicit value
    rd(5'd31, d);
    check("R6 lane order", d, 128'h0001_0002_0004_0008_0010_0020_0040_0080);
    // R4/R5 explicit
    rd(5'd30, d);
    check("R5 top bits lost", d, 128'h8000_8000_8000_8000_8000_8000_8000_8000);
    rd(5'd29, d);
    check("R5 no cross-lane carry", d, 128'h0002_0002_0002_0002_0002_0002_0002_0002);

    // R7: destination equals source A
    wr(5'd20, 128'h0003_0003_0003_0003_0003_0003_0003_0003);
    wr(5'd21, 128'h0002_0002_0002_0002_0002_0002_0002_0002);
    issue(mk(6'd4, 5'd20, 5'd20, 5'd21, 11'd324), 1, dn, il);
    rd(5'd20, d);
    check("R7 overlap uses old value", d, 128'h000C_000C_000C_000C_000C_000C_000C_000C);

    // R8: wrong extended opcode
    wr(5'd22, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    issue(mk(6'd4, 5'd22, 5'd20, 5'd21, 11'd580), 1, dn, il);
    check("R8 illegal ext", {126'd0, dn, il}, 128'd1);
    rd(5'd22, d);
    check("R8 no write ext", d, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    // R8: wrong primary opcode
    issue(mk(6'd5, 5'd22, 5'd20, 5'd21, 11'd324), 1, dn, il);
    check("R8 illegal pri", {126'd0, dn, il}, 128'd1);
    rd(5'd22, d);
    check("R8 no write pri", d, 128'h1111_2222_3333_4444_5555_6666_7777_8888);

    // R12: matching word with the strobe low
    issue(mk(6'd4, 5'd22, 5'd20, 5'd21, 11'd324), 0, dn, il);
    check("R12 no pulses", {126'd0, dn, il}, '0);
    rd(5'd22, d);
    check("R12 no write", d, 128'h1111_2222_3333_4444_5555_6666_7777_8888);

    // R11: debug write and execution to the same register
    @(negedge clk);
    instr_valid = 1; instr_word = mk(6'd4, 5'd23, 5'd21, 5'd21, 11'd324);
    dbg_we = 1; dbg_waddr = 5'd23; dbg_wdata = {8{16'hDEAD}};
    @(negedge clk);
    instr_valid = 0; dbg_we = 0;
    rd(5'd23, d);
    check("R11 instruction wins", d, 128'h0008_0008_0008_0008_0008_0008_0008_0008);

    // R10: debug path on its own
    wr(5'd9, 128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF);
    rd(5'd9, d);
    check("R10 debug round trip", d, 128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF);

    // R9: reset clears written registers
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(5'd9, d);  check("R9 reg9 cleared", d, '0);
    rd(5'd31, d); check("R9 reg31 cleared", d, '0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule